// File: doc/BRIEF.md
# Floating-Point Compare Flag Generator

This block compares two binary32 floating-point values, a first operand `op_d` and a second operand `op_m`. It returns a four-bit condition code and an invalid-operation flag. The comparison works directly on the packed encodings. No unpacking, normalisation or rounding takes place.

A mode input chooses between a quiet compare and a signalling compare. In the signalling compare, any NaN raises invalid. A second input replaces `op_m` with positive zero, which gives the compare-against-zero forms.

The compare logic itself is combinational. Its result is captured in a register stage that a two-state machine controls:

- `ST_IDLE`: no result is being presented.
- `ST_SHOW`: a fresh result is on the outputs.

The transitions are:

- `ST_IDLE` → `ST_SHOW` when `in_valid` is high at a clock edge.
- `ST_SHOW` → `ST_SHOW` when `in_valid` is high again.
- `ST_SHOW` → `ST_IDLE` when `in_valid` is low.
- `ST_IDLE` → `ST_IDLE` when `in_valid` is low.

Top module: `fpcmp_flags`

## Requirements
- R1: The output `nzcv` packs four bits as {N,Z,C,V}, with N in bit 3 and V in bit 0. The four possible results are coded as follows: equal is 4'b0110, less-than is 4'b1000, greater-than is 4'b0010 and unordered is 4'b0011. No other code is ever presented while `out_valid` is high.
- R2: An operand whose exponent bits [30:23] are all ones and whose fraction bits [22:0] are nonzero is a NaN. If either operand is a NaN, the result is unordered. An infinity (all-ones exponent, zero fraction) is not a NaN.
- R3: A NaN with fraction bit 22 clear is signalling. It raises `invalid` in both compare modes.
- R4: With `signal_mode`=1, a quiet NaN (fraction bit 22 set) also raises `invalid`. With `signal_mode`=0, a quiet NaN leaves `invalid` low. An ordered compare never raises `invalid`.
- R5: Two operands are equal when their bit patterns match, or when both have bits [30:0] zero. As a consequence, +0 equals -0.
- R6: When the sign bits (bit 31) differ and the operands are not both zero, the operand with the sign bit set is the smaller one.
- R7: When both operands are non-negative, they are ordered by their 32-bit patterns read as unsigned integers. Infinities follow the same rule.
- R8: When both operands are negative, the integer ordering of R7 is reversed.
- R9: With `zero_m`=1, the value on `op_m` is ignored and +0 is compared in its place. This holds in both modes.
- R10: A compare presented with `in_valid` at a clock edge appears on `nzcv` and `invalid` after that edge, with `out_valid` high. A cycle without `in_valid` drops `out_valid` at the next edge and leaves `nzcv` and `invalid` unchanged.
- R11: While `rst_n` is low, `out_valid`, `nzcv` and `invalid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_d | input | 32 | First operand, binary32 encoding |
| op_m | input | 32 | Second operand, binary32 encoding |
| signal_mode | input | 1 | 1 selects the signalling compare (quiet NaN raises invalid) |
| zero_m | input | 1 | 1 compares `op_d` against +0 instead of `op_m` |
| out_valid | output | 1 | Registered result is fresh |
| nzcv | output | 4 | Condition code {N,Z,C,V} |
| invalid | output | 1 | Invalid-operation flag for this compare |

## Verification
Every decision in the block lands in a single register stage. A wrong classification or ordering decision therefore shows up on `nzcv` or `invalid` exactly one edge after the offending operands are presented. A state-machine fault shows up as `out_valid` at the wrong level in that same cycle, or as flags that change after a cycle without `in_valid`. The directed vectors target the places where a fault would hide:

- the sign-bit and fraction-MSB boundaries of the NaN classes;
- the pair of zero encodings;
- equal-sign negative pairs, where the ordering must be reversed.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } fcmp_state_e;

    typedef enum logic [1:0] {
        REL_EQ = 2'd0,
        REL_LT = 2'd1,
        REL_GT = 2'd2
    } fcmp_rel_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } fcmp_nzcv_t;

    localparam fcmp_nzcv_t CODE_EQ    = '{n: 1'b0, z: 1'b1, c: 1'b1, v: 1'b0};
    localparam fcmp_nzcv_t CODE_LT    = '{n: 1'b1, z: 1'b0, c: 1'b0, v: 1'b0};
    localparam fcmp_nzcv_t CODE_GT    = '{n: 1'b0, z: 1'b0, c: 1'b1, v: 1'b0};
    localparam fcmp_nzcv_t CODE_UNORD = '{n: 1'b0, z: 1'b0, c: 1'b1, v: 1'b1};

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
    parameter int WIDTH = 32,
    parameter int EXP_W = 8
) (
    input  logic [WIDTH-1:0] opnd,
    output logic             is_nan,
    output logic             is_snan,
    output logic             mag_zero,
    output logic             neg
);
    localparam int FRAC_W = WIDTH - 1 - EXP_W;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    always_comb begin
        exp_f    = opnd[WIDTH-2 -: EXP_W];
        frac_f   = opnd[FRAC_W-1:0];
        // All-ones exponent with any fraction bit set marks a NaN.
        is_nan   = (&exp_f) && (|frac_f);
        // Top fraction bit clear means the NaN is the signalling kind.
        is_snan  = is_nan && !frac_f[FRAC_W-1];
        mag_zero = ~|opnd[WIDTH-2:0];
        neg      = opnd[WIDTH-1];
    end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] val_d,
    input  logic [WIDTH-1:0] val_m,
    input  logic             d_neg,
    input  logic             m_neg,
    input  logic             d_zero,
    input  logic             m_zero,
    output fcmp_rel_e        rel
);
    logic raw_lt;
    logic raw_gt;

    always_comb begin
        raw_lt = val_d < val_m;
        raw_gt = val_d > val_m;
        rel    = REL_EQ;
        if ((val_d == val_m) || (d_zero && m_zero)) begin
            rel = REL_EQ;
        end else if (d_neg != m_neg) begin
            // With opposite signs, the negative operand is the smaller one.
            rel = d_neg ? REL_LT : REL_GT;
        end else if (d_neg ^ raw_lt) begin
            // Integer order of the bit patterns, reversed for negatives.
            rel = REL_LT;
        end else if (d_neg ^ raw_gt) begin
            rel = REL_GT;
        end
    end
endmodule

// File: rtl/fcmp_decide.sv
module fcmp_decide
    import fcmp_pkg::*;
(
    input  logic [1:0]  nan_any,
    input  logic [1:0]  nan_sig,
    input  logic        signal_mode,
    input  fcmp_rel_e   rel,
    output fcmp_nzcv_t  code,
    output logic        inv
);
    logic unord;

    always_comb begin
        unord = |nan_any;
        inv   = (|nan_sig) || (signal_mode && unord);
        code  = '0;
        if (unord) begin
            code = CODE_UNORD;
        end else begin
            unique case (rel)
                REL_EQ:  code = CODE_EQ;
                REL_LT:  code = CODE_LT;
                REL_GT:  code = CODE_GT;
                default: code = '0;
            endcase
        end
    end
endmodule

// File: rtl/fcmp_result_reg.sv
module fcmp_result_reg
    import fcmp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  fcmp_nzcv_t  code_nxt,
    input  logic        inv_nxt,
    output logic        out_valid,
    output fcmp_nzcv_t  code_q,
    output logic        inv_q
);
    fcmp_state_e state_q;
    fcmp_state_e state_nxt;

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE: state_nxt = in_valid ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_nxt = in_valid ? ST_SHOW : ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            inv_q  <= 1'b0;
        end else if (in_valid) begin
            code_q <= code_nxt;
            inv_q  <= inv_nxt;
        end
    end

    assign out_valid = (state_q == ST_SHOW);

    p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(code_q) && $stable(inv_q)));
endmodule

// File: rtl/fpcmp_flags.sv
module fpcmp_flags
    import fcmp_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int EXP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] op_d,
    input  logic [WIDTH-1:0] op_m,
    input  logic             signal_mode,
    input  logic             zero_m,
    output logic             out_valid,
    output logic [3:0]       nzcv,
    output logic             invalid
);
    localparam int N_OPS = 2;

    logic [WIDTH-1:0] m_eff;
    logic [WIDTH-1:0] opnd [N_OPS];
    logic [N_OPS-1:0] cls_nan;
    logic [N_OPS-1:0] cls_snan;
    logic [N_OPS-1:0] cls_zero;
    logic [N_OPS-1:0] cls_neg;
    fcmp_rel_e        rel;
    fcmp_nzcv_t       code_nxt;
    fcmp_nzcv_t       code_q;
    logic             inv_nxt;
    logic             inv_q;

    // The compare-against-zero option replaces the second operand with +0.
    assign m_eff   = zero_m ? '0 : op_m;
    assign opnd[0] = op_d;
    assign opnd[1] = m_eff;

    for (genvar g = 0; g < N_OPS; g++) begin : g_cls
        fcmp_classify #(.WIDTH(WIDTH), .EXP_W(EXP_W)) u_cls (
            .opnd     (opnd[g]),
            .is_nan   (cls_nan[g]),
            .is_snan  (cls_snan[g]),
            .mag_zero (cls_zero[g]),
            .neg      (cls_neg[g])
        );
    end

    fcmp_order #(.WIDTH(WIDTH)) u_order (
        .val_d  (op_d),
        .val_m  (m_eff),
        .d_neg  (cls_neg[0]),
        .m_neg  (cls_neg[1]),
        .d_zero (cls_zero[0]),
        .m_zero (cls_zero[1]),
        .rel    (rel)
    );

    fcmp_decide u_decide (
        .nan_any     (cls_nan),
        .nan_sig     (cls_snan),
        .signal_mode (signal_mode),
        .rel         (rel),
        .code        (code_nxt),
        .inv         (inv_nxt)
    );

    fcmp_result_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .code_nxt  (code_nxt),
        .inv_nxt   (inv_nxt),
        .out_valid (out_valid),
        .code_q    (code_q),
        .inv_q     (inv_q)
    );

    assign nzcv    = {code_q.n, code_q.z, code_q.c, code_q.v};
    assign invalid = inv_q;

    p_legal_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (nzcv inside {4'b0110, 4'b1000, 4'b0010, 4'b0011}));
    p_nan_unordered_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (|cls_nan)) |=> (nzcv == 4'b0011));
    p_snan_invalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (|cls_snan)) |=> invalid);
    p_ordered_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(|cls_nan)) |=> !invalid);
    p_zeros_equal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (&cls_zero)) |=> (nzcv == 4'b0110));
endmodule

// File: tb/fpcmp_flags_test.sv
module fpcmp_flags_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_d = '0;
    logic [31:0] op_m = '0;
    logic        signal_mode = 1'b0;
    logic        zero_m = 1'b0;
    logic        out_valid;
    logic [3:0]  nzcv;
    logic        invalid;

    int n_vec  = 0;
    int n_fail = 0;

    localparam logic [3:0] EQ = 4'b0110, LT = 4'b1000, GT = 4'b0010, UN = 4'b0011;
    localparam logic [31:0] P1 = 32'h3F80_0000, P2 = 32'h4000_0000;
    localparam logic [31:0] N1 = 32'hBF80_0000, N2 = 32'hC000_0000;
    localparam logic [31:0] PZ = 32'h0000_0000, NZ = 32'h8000_0000;
    localparam logic [31:0] PINF = 32'h7F80_0000, NINF = 32'hFF80_0000;
    localparam logic [31:0] QNAN = 32'h7FC0_0000, SNAN = 32'h7F80_0001;
    localparam logic [31:0] NQNAN = 32'hFFC0_0000;

    always #10 clk = ~clk;

    fpcmp_flags uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_d(op_d), .op_m(op_m),
        .signal_mode(signal_mode), .zero_m(zero_m), .out_valid(out_valid),
        .nzcv(nzcv), .invalid(invalid)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic run_vec(input logic [31:0] d, input logic [31:0] m, input logic sig,
                           input logic zm, input logic [3:0] ef, input logic ei,
                           input string tag);
        @(negedge clk);
        op_d = d; op_m = m; signal_mode = sig; zero_m = zm; in_valid = 1'b1;
        @(posedge clk);
        #2;
        check({31'd0, out_valid}, 32'd1, {tag, " R10 out_valid"});
        check({28'd0, nzcv}, {28'd0, ef}, {tag, " nzcv"});
        check({31'd0, invalid}, {31'd0, ei}, {tag, " invalid"});
    endtask

    task automatic t_reset();
        #2;
        check({31'd0, out_valid}, 32'd0, "R11 out_valid in reset");
        check({28'd0, nzcv}, 32'd0, "R11 nzcv in reset");
        check({31'd0, invalid}, 32'd0, "R11 invalid in reset");
    endtask

    task automatic t_positive();
        run_vec(P1, P2, 1'b0, 1'b0, LT, 1'b0, "R1 R7 1<2");
        run_vec(P2, P1, 1'b0, 1'b0, GT, 1'b0, "R1 R7 2>1");
        run_vec(P1, P1, 1'b0, 1'b0, EQ, 1'b0, "R5 same bits");
        run_vec(PINF, P2, 1'b0, 1'b0, GT, 1'b0, "R2 R7 +inf>2");
        run_vec(PINF, PINF, 1'b1, 1'b0, EQ, 1'b0, "R2 R4 inf equal, sig mode");
    endtask

    task automatic t_signs();
        run_vec(N1, P1, 1'b0, 1'b0, LT, 1'b0, "R6 -1<1");
        run_vec(P1, N2, 1'b0, 1'b0, GT, 1'b0, "R6 1>-2");
        run_vec(PZ, NZ, 1'b0, 1'b0, EQ, 1'b0, "R5 +0==-0");
        run_vec(NZ, PZ, 1'b1, 1'b0, EQ, 1'b0, "R5 -0==+0 sig");
    endtask

    task automatic t_negative();
        run_vec(N1, N2, 1'b0, 1'b0, GT, 1'b0, "R8 -1>-2");
        run_vec(N2, N1, 1'b0, 1'b0, LT, 1'b0, "R8 -2<-1");
        run_vec(NINF, N2, 1'b0, 1'b0, LT, 1'b0, "R8 -inf<-2");
    endtask

    task automatic t_nan();
        run_vec(QNAN, P1, 1'b0, 1'b0, UN, 1'b0, "R2 R4 qnan quiet");
        run_vec(P1, QNAN, 1'b1, 1'b0, UN, 1'b1, "R4 qnan signalling mode");
        run_vec(SNAN, P1, 1'b0, 1'b0, UN, 1'b1, "R3 snan quiet mode");
        run_vec(P1, SNAN, 1'b1, 1'b0, UN, 1'b1, "R3 snan sig mode");
        run_vec(NQNAN, NQNAN, 1'b0, 1'b0, UN, 1'b0, "R2 equal-pattern nans");
        run_vec(N1, P2, 1'b1, 1'b0, LT, 1'b0, "R4 ordered sig mode no invalid");
    endtask

    task automatic t_zero_opt();
        run_vec(P1, SNAN, 1'b0, 1'b1, GT, 1'b0, "R9 m ignored, 1>+0");
        run_vec(N2, QNAN, 1'b1, 1'b1, LT, 1'b0, "R9 m ignored, -2<+0");
        run_vec(NZ, N1, 1'b0, 1'b1, EQ, 1'b0, "R9 -0 vs +0");
        run_vec(QNAN, P1, 1'b1, 1'b1, UN, 1'b1, "R9 R4 d nan vs zero");
    endtask

    task automatic t_idle();
        run_vec(P2, P1, 1'b0, 1'b0, GT, 1'b0, "R10 before idle");
        @(negedge clk);
        in_valid = 1'b0; op_d = SNAN; op_m = P1;
        @(posedge clk);
        #2;
        check({31'd0, out_valid}, 32'd0, "R10 idle out_valid");
        check({28'd0, nzcv}, {28'd0, GT}, "R10 idle nzcv held");
        check({31'd0, invalid}, 32'd0, "R10 idle invalid held");
        run_vec(P1, P2, 1'b0, 1'b0, LT, 1'b0, "R10 after idle");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_positive();
        t_signs();
        t_negative();
        t_nan();
        t_zero_opt();
        t_idle();
        @(negedge clk);
        in_valid = 1'b0;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule